// File: doc/BRIEF.md
# DMA Channel Count and Termination Unit

This block keeps the transfer counters for a four-channel DMA controller and decides, after every transferred unit, whether a channel goes on or stops. Each channel holds a base count, a current count and a two-bit transfer mode. It also latches a request from its hardware line, keeps a software request bit and latches an external end request. The data mover pulses a per-channel "unit started" strobe and a "unit done" strobe. On each done strobe the unit decrements the count and applies the stop rule for the channel's mode.

A channel stops in one of four ways. The count can wrap from zero to all ones, which is terminal count. An external end request can stop it in any mode except single. In demand mode it stops when its request line is low. In single mode it stops after every unit. Only terminal count sets the channel's status bit and fires its terminal-count pulse. Address generation, data movement and bus timing are handled by neighbouring blocks.

Top module: `dct_top`

## Requirements
- R1: A mode write stores bits 7:6 of the written byte as the selected channel's mode: 00 demand, 01 single, 10 burst, 11 cascade. Reset selects demand.
- R2: Each done strobe decrements the channel's current count by one, modulo 2^16, in every mode.
- R3: A done strobe while the current count is 0x0000 is terminal count. One cycle later, term and tc_pulse are high for one cycle, the channel's tc_status bit is set, and its request bit, software request bit and end latch are clear.
- R4: A done strobe with a nonzero count, in a mode other than single, with the end latch set, stops the channel. term pulses, tc_pulse stays low, and the request, software request and end latch are cleared.
- R5: In demand mode, a done strobe with a nonzero count and no end latch, while the channel's hw_req line is low, stops the channel with term and without tc_pulse.
- R6: In single mode, a done strobe with a nonzero count pulses term, clears the request and software request bits, and leaves the end latch and tc_status unchanged.
- R7: In burst and cascade modes, a done strobe with a nonzero count and no end latch produces no term pulse and leaves the request bits as they were.
- R8: A count write loads both base and current count of the selected channel and clears its tc_status bit. It takes precedence over a done strobe to the same channel in the same cycle, and that strobe is then ignored apart from acknowledge.
- R9: ack is high when idle. It goes low the cycle after a start strobe and returns high the cycle after a done strobe; done wins if both strobes arrive together.
- R10: When terminal count and an end latch hold together, terminal count wins and tc_pulse fires.
- R11: Synchronous reset clears counts, status, request, software request, end latches and pulses, sets every ack high and selects demand mode.
- R12: A channel's request bit sets on a rising edge of its hw_req line and clears while the line is low or when the channel stops.
- R13: A software request write loads all four software request bits. A stop of a channel in the same cycle clears that channel's bit instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr | input | 1 | Count register write strobe |
| reg_sel | input | 2 | Channel addressed by count and mode writes |
| cnt_wdata | input | 16 | Count value to load |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode byte, mode in bits 7:6 |
| sw_req_wr | input | 1 | Software request write strobe |
| sw_req_wdata | input | 4 | Software request bits, one per channel |
| unit_start | input | 4 | Per-channel unit-begin strobe |
| unit_done | input | 4 | Per-channel unit-complete strobe |
| hw_req | input | 4 | Hardware request lines |
| end_req | input | 4 | External end-request inputs |
| term | output | 4 | One-cycle pulse when a channel stops |
| tc_pulse | output | 4 | One-cycle pulse on terminal count |
| tc_status | output | 4 | Terminal-count status bits |
| req_bits | output | 4 | Latched hardware request bits |
| sreq_bits | output | 4 | Software request bits |
| ack | output | 4 | Acknowledge lines, high when idle |
| cur_count | output | 64 | Current counts, channel n in bits 16n+15:16n |
| base_count | output | 64 | Base counts, same packing |

## Verification
A wrong current count first shows in cur_count. It shows up at the ports a second time when terminal count fires one unit early or late. A stale end latch shows as a term pulse without tc_pulse on the channel's next done strobe. The bench only sees that latch through this term pulse, so it drives done strobes densely enough for a bad latch to surface within a few cycles. Request and status errors appear on req_bits, sreq_bits and tc_status one cycle after the strobe that should have changed them. Every output is compared against an independent model on every cycle.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [1:0] {
    XM_DEMAND  = 2'b00,
    XM_SINGLE  = 2'b01,
    XM_BURST   = 2'b10,
    XM_CASCADE = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/dct_count.sv
module dct_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cur,
  output logic [CW-1:0] base,
  output logic          at_zero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      base <= '0;
    end else if (load) begin
      cur  <= load_val;
      base <= load_val;
    end else if (dec) begin
      cur <= cur - 1'b1;
    end
  end

  assign at_zero = (cur == '0);

  // R2: one decrement per strobe
  a_r2_decrement: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |=> (cur == $past(cur) - 1'b1));
endmodule

// File: rtl/dct_chan.sv
module dct_chan
  import dct_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_val,
  input  logic          mode_wr,
  input  logic [1:0]    mode_val,
  input  logic          unit_start,
  input  logic          unit_done,
  input  logic          hw_line,
  input  logic          sw_wr,
  input  logic          sw_val,
  input  logic          end_line,
  output logic          term,
  output logic          tc_pulse,
  output logic          tc_stat,
  output logic          req,
  output logic          sreq,
  output logic          ack,
  output logic [CW-1:0] cur,
  output logic [CW-1:0] base
);
  xfer_mode_e mode_q;
  logic       end_q, hw_prev, at_zero;
  logic       done_eff, single, hit_tc, hit_end, hit_dem, hit_sgl, stop, clr_req;

  assign done_eff = unit_done && !cnt_wr;
  assign single   = (mode_q == XM_SINGLE);
  assign hit_tc   = done_eff && at_zero;
  assign hit_end  = done_eff && !at_zero && !single && end_q;
  assign hit_dem  = done_eff && !at_zero && !single && !end_q &&
                    (mode_q == XM_DEMAND) && !hw_line;
  assign hit_sgl  = done_eff && !at_zero && single;
  assign stop     = hit_tc || hit_end || hit_dem;
  assign clr_req  = stop || hit_sgl;

  dct_count #(.CW(CW)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_wr),
    .load_val (cnt_val),
    .dec      (done_eff),
    .cur      (cur),
    .base     (base),
    .at_zero  (at_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= XM_DEMAND;
      end_q    <= 1'b0;
      hw_prev  <= 1'b0;
      req      <= 1'b0;
      sreq     <= 1'b0;
      tc_stat  <= 1'b0;
      ack      <= 1'b1;
      term     <= 1'b0;
      tc_pulse <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= xfer_mode_e'(mode_val);
      hw_prev  <= hw_line;
      term     <= clr_req;
      tc_pulse <= hit_tc;

      if (clr_req || !hw_line) req <= 1'b0;
      else if (!hw_prev)       req <= 1'b1;

      if (clr_req)    sreq <= 1'b0;
      else if (sw_wr) sreq <= sw_val;

      if (stop) end_q <= 1'b0;
      else      end_q <= end_q || end_line;

      if (cnt_wr)      tc_stat <= 1'b0;
      else if (hit_tc) tc_stat <= 1'b1;

      if (unit_done)       ack <= 1'b1;
      else if (unit_start) ack <= 1'b0;
    end
  end

  // R3: terminal count sets status and pulse and clears requests
  a_r3_tc_sets: assert property (@(posedge clk) disable iff (rst)
    (unit_done && !cnt_wr && cur == '0) |=> (tc_stat && tc_pulse && term && !req && !sreq));
  // R4: end request stops without terminal count
  a_r4_end_no_tc: assert property (@(posedge clk) disable iff (rst)
    (unit_done && !cnt_wr && cur != '0 && mode_q != XM_SINGLE && end_q)
      |=> (term && !tc_pulse && !end_q && !req));
  // R6: single mode drops both requests after a unit
  a_r6_single_clear: assert property (@(posedge clk) disable iff (rst)
    (unit_done && !cnt_wr && cur != '0 && mode_q == XM_SINGLE)
      |=> (term && !tc_pulse && !req && !sreq));
  // R7: burst keeps running without an end cause
  a_r7_burst_runs: assert property (@(posedge clk) disable iff (rst)
    (unit_done && !cnt_wr && cur != '0 && mode_q == XM_BURST && !end_q) |=> !term);
  // R8: count write loads and clears status
  a_r8_write_load: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cur == $past(cnt_val) && base == $past(cnt_val) && !tc_stat));
  // R9: acknowledge follows the strobes
  a_r9_ack_low: assert property (@(posedge clk) disable iff (rst)
    (unit_start && !unit_done) |=> !ack);
  a_r9_ack_high: assert property (@(posedge clk) disable iff (rst)
    unit_done |=> ack);
  // R3: terminal-count pulse implies a stop pulse
  a_r3_pulse_pair: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> term);
endmodule

// File: rtl/dct_top.sv
module dct_top #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  localparam int SW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_wr,
  input  logic [SW-1:0]     reg_sel,
  input  logic [CW-1:0]     cnt_wdata,
  input  logic              mode_wr,
  input  logic [7:0]        mode_wdata,
  input  logic              sw_req_wr,
  input  logic [NCH-1:0]    sw_req_wdata,
  input  logic [NCH-1:0]    unit_start,
  input  logic [NCH-1:0]    unit_done,
  input  logic [NCH-1:0]    hw_req,
  input  logic [NCH-1:0]    end_req,
  output logic [NCH-1:0]    term,
  output logic [NCH-1:0]    tc_pulse,
  output logic [NCH-1:0]    tc_status,
  output logic [NCH-1:0]    req_bits,
  output logic [NCH-1:0]    sreq_bits,
  output logic [NCH-1:0]    ack,
  output logic [NCH*CW-1:0] cur_count,
  output logic [NCH*CW-1:0] base_count
);
  logic [5:0] mode_unused_bits;
  assign mode_unused_bits = mode_wdata[5:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_hit;
    assign sel_hit = (reg_sel == SW'(c));

    dct_chan #(.CW(CW)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .cnt_wr     (cnt_wr && sel_hit),
      .cnt_val    (cnt_wdata),
      .mode_wr    (mode_wr && sel_hit),
      .mode_val   (mode_wdata[7:6]),
      .unit_start (unit_start[c]),
      .unit_done  (unit_done[c]),
      .hw_line    (hw_req[c]),
      .sw_wr      (sw_req_wr),
      .sw_val     (sw_req_wdata[c]),
      .end_line   (end_req[c]),
      .term       (term[c]),
      .tc_pulse   (tc_pulse[c]),
      .tc_stat    (tc_status[c]),
      .req        (req_bits[c]),
      .sreq       (sreq_bits[c]),
      .ack        (ack[c]),
      .cur        (cur_count[c*CW +: CW]),
      .base       (base_count[c*CW +: CW])
    );
  end

  // R11: after reset all channels are idle
  a_r11_reset_idle: assert property (@(posedge clk)
    rst |=> (ack == '1 && term == '0 && tc_status == '0 && req_bits == '0));
endmodule

// File: tb/dct_top_tb.sv
module dct_top_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, cnt_wr, mode_wr, sw_req_wr;
  logic [1:0]  reg_sel;
  logic [15:0] cnt_wdata;
  logic [7:0]  mode_wdata;
  logic [3:0]  sw_req_wdata, unit_start, unit_done, hw_req, end_req;
  logic [3:0]  term, tc_pulse, tc_status, req_bits, sreq_bits, ack;
  logic [63:0] cur_count, base_count;

  dct_top u_dut (
    .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .reg_sel(reg_sel), .cnt_wdata(cnt_wdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .sw_req_wr(sw_req_wr),
    .sw_req_wdata(sw_req_wdata), .unit_start(unit_start), .unit_done(unit_done),
    .hw_req(hw_req), .end_req(end_req), .term(term), .tc_pulse(tc_pulse),
    .tc_status(tc_status), .req_bits(req_bits), .sreq_bits(sreq_bits), .ack(ack),
    .cur_count(cur_count), .base_count(base_count)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_cur [4];
  logic [15:0] m_base[4];
  logic [1:0]  m_mode[4];
  logic [3:0]  m_req, m_sreq, m_end, m_tc, m_ack, m_term, m_tcp, m_hwp;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      m_cur[c] = '0; m_base[c] = '0; m_mode[c] = 2'b00;
    end
    m_req = '0; m_sreq = '0; m_end = '0; m_tc = '0; m_ack = '1;
    m_term = '0; m_tcp = '0; m_hwp = '0;
  endtask

  function automatic logic [63:0] pack16(input logic [15:0] a0, a1, a2, a3);
    return {a3, a2, a1, a0};
  endfunction

  task automatic model_step();
    logic [3:0] n_req, n_sreq, n_end, n_tc, n_ack, n_term, n_tcp;
    if (rst) begin model_reset(); return; end
    n_req = m_req; n_sreq = m_sreq; n_end = m_end; n_tc = m_tc; n_ack = m_ack;
    n_term = '0; n_tcp = '0;
    for (int c = 0; c < 4; c++) begin
      logic wr, dn, z, sg, htc, hen, hdm, hsg, stp, clr;
      wr  = cnt_wr && (reg_sel == c[1:0]);
      dn  = unit_done[c] && !wr;
      z   = (m_cur[c] == 16'h0000);
      sg  = (m_mode[c] == 2'b01);
      htc = dn && z;
      hen = dn && !z && !sg && m_end[c];
      hdm = dn && !z && !sg && !m_end[c] && (m_mode[c] == 2'b00) && !hw_req[c];
      hsg = dn && !z && sg;
      stp = htc || hen || hdm;
      clr = stp || hsg;
      n_term[c] = clr;
      n_tcp[c]  = htc;
      if (clr || !hw_req[c]) n_req[c] = 1'b0;
      else if (!m_hwp[c])    n_req[c] = 1'b1;
      if (clr)            n_sreq[c] = 1'b0;
      else if (sw_req_wr) n_sreq[c] = sw_req_wdata[c];
      n_end[c] = stp ? 1'b0 : (m_end[c] || end_req[c]);
      if (wr)       n_tc[c] = 1'b0;
      else if (htc) n_tc[c] = 1'b1;
      if (unit_done[c])       n_ack[c] = 1'b1;
      else if (unit_start[c]) n_ack[c] = 1'b0;
      if (wr) begin m_cur[c] = cnt_wdata; m_base[c] = cnt_wdata; end
      else if (dn) m_cur[c] = m_cur[c] - 16'd1;
      if (mode_wr && (reg_sel == c[1:0])) m_mode[c] = mode_wdata[7:6];
    end
    m_req = n_req; m_sreq = n_sreq; m_end = n_end; m_tc = n_tc; m_ack = n_ack;
    m_term = n_term; m_tcp = n_tcp; m_hwp = hw_req;
  endtask

  task automatic compare_all();
    chk("R3/R4/R5/R6/R7 term",  {60'd0, term},      {60'd0, m_term});
    chk("R3/R10 tc_pulse",      {60'd0, tc_pulse},  {60'd0, m_tcp});
    chk("R3/R8 tc_status",      {60'd0, tc_status}, {60'd0, m_tc});
    chk("R12 req_bits",         {60'd0, req_bits},  {60'd0, m_req});
    chk("R13 sreq_bits",        {60'd0, sreq_bits}, {60'd0, m_sreq});
    chk("R9 ack",               {60'd0, ack},       {60'd0, m_ack});
    chk("R2 cur_count",  cur_count,  pack16(m_cur[0], m_cur[1], m_cur[2], m_cur[3]));
    chk("R8 base_count", base_count, pack16(m_base[0], m_base[1], m_base[2], m_base[3]));
  endtask

  task automatic idle_inputs();
    cnt_wr = 0; mode_wr = 0; sw_req_wr = 0; reg_sel = 0; cnt_wdata = 0;
    mode_wdata = 0; sw_req_wdata = 0; unit_start = 0; unit_done = 0; end_req = 0;
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic wr_cnt(int ch, logic [15:0] v);
    cnt_wr = 1; reg_sel = ch[1:0]; cnt_wdata = v; step();
  endtask

  task automatic wr_mode(int ch, logic [1:0] m);
    mode_wr = 1; reg_sel = ch[1:0]; mode_wdata = {m, 6'b101010}; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; hw_req = 0; idle_inputs(); model_reset();
    repeat (3) @(negedge clk);
    compare_all(); // R11 reset state
    rst = 0;

    // R1/R3: burst channel 0, count 1, wraps after two units
    wr_cnt(0, 16'd1); wr_mode(0, 2'b10);
    hw_req[0] = 1; step();
    unit_start[0] = 1; step();           // R9 ack low
    unit_done[0] = 1; step();            // R7 no stop
    unit_done[0] = 1; step();            // R3 terminal count
    wr_cnt(0, 16'd4);                    // R8 clears status
    // R4: demand channel 1 with end request
    wr_cnt(1, 16'd5); hw_req[1] = 1; step();
    end_req[1] = 1; step();
    unit_done[1] = 1; step();
    // R5: demand channel 1 with line low
    hw_req[1] = 0; unit_done[1] = 1; step();
    // R10: burst channel 2 at zero with end latched
    wr_mode(2, 2'b10); end_req[2] = 1; step();
    unit_done[2] = 1; step();
    // R6: single channel 3 with end latched (kept)
    wr_cnt(3, 16'd3); wr_mode(3, 2'b01);
    hw_req[3] = 1; sw_req_wr = 1; sw_req_wdata = 4'b1000; end_req[3] = 1; step();
    unit_done[3] = 1; step();
    // R7: cascade keeps going
    wr_cnt(2, 16'd2); wr_mode(2, 2'b11); unit_done[2] = 1; step();
    // R8: write and done together on the same channel
    cnt_wr = 1; reg_sel = 2; cnt_wdata = 16'd9; unit_done[2] = 1; step();

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0) begin cnt_wr = 1; reg_sel = r[5:4]; cnt_wdata = 16'($urandom_range(0, 4)); end
      if (r[9:6] == 4'd1) begin mode_wr = 1; reg_sel = r[11:10]; mode_wdata = 8'($urandom); end
      if (r[14:12] == 3'd0) begin sw_req_wr = 1; sw_req_wdata = 4'($urandom); end
      unit_start = 4'($urandom) & 4'($urandom);
      unit_done  = 4'($urandom) & 4'($urandom);
      if (r[17:15] == 3'd0) hw_req = 4'($urandom);
      end_req = (r[20:18] == 3'd0) ? 4'($urandom) : 4'b0000;
      rst = (r[31:22] == 10'd0);   // occasional R11 reset
      step();
      rst = 0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule